// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a supervision timer for a processor subsystem. A free-running prescaler feeds a two-bit overflow counter, and the fourth advance of that counter is the watchdog event. Software keeps the watchdog quiet by writing a key byte to a code slot on a byte-wide write-only register bus. The key clears only the two-bit counter. The prescaler is never restarted, so the real time left after a clear lies between three quarters of the nominal detection time and the full detection time.

A control slot holds an enable flag, a two-bit detection-time select and an output-mode flag. On an overflow the block either pulses an interrupt request for one clock or drives a reset output for a parameterised number of clocks. Counting then restarts from zero. Stopping the watchdog takes two steps: clear the enable flag, then write a separate stop key. Once software selects interrupt mode, it cannot return to reset mode. The prescaler tap used for each detection time is a parameter.

Top module: `kwdt_top`

## Requirements
- R1: After reset the block is enabled and counting, detection select 0 and reset-output mode are in force, and both outputs are low.
- R2: With detection select s (control bits 2:1), the counter advances once every 2^(TAPs+1) clocks. Successive overflows are exactly 4·2^(TAPs+1) clocks apart.
- R3: Writing 0x4E to the code slot (bus_addr = 1) clears the two-bit counter and leaves the prescaler running. The next overflow follows between 3/4 and all of the detection time. Clears repeated faster than 3/4 of it prevent any overflow.
- R4: A code-slot byte other than 0x4E and 0xB1 changes nothing, and overflows continue on schedule.
- R5: Writing 0xB1 to the code slot stops counting only while the enable flag (control bit 3) is 0. With the flag at 1 the write has no effect.
- R6: Writing 0 to the enable flag alone does not stop counting, and overflows keep occurring.
- R7: Writing 1 to the enable flag while it is 0 restarts counting from a cleared counter. The next overflow follows between 3/4 and all of the detection time.
- R8: Control bit 0 picks the overflow action. With 1, wdt_rst is high for exactly RST_CYCLES clocks and wdt_irq stays low. With 0, wdt_irq is high for exactly one clock and wdt_rst stays low.
- R9: Once control bit 0 has been written as 0, a later write of 1 leaves interrupt mode in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per clock |
| bus_addr | input | 1 | Slot select: 0 control, 1 code |
| bus_wdata | input | 8 | Write data |
| wdt_irq | output | 1 | One-clock interrupt request on overflow |
| wdt_rst | output | 1 | Reset request held RST_CYCLES clocks on overflow |

## Verification
The assertions assume that every bus write lasts one clock and uses only the two slot addresses. They also assume the detection select does not change in the same cycle as a prescaler tick they are judging, and that RST_CYCLES is shorter than the shortest detection time. The stimulus follows these rules: each write is one clock wide, the select changes only through control writes, and each change is followed at once by a clear key. Timing checks use windows derived from the three-quarter rule, so the free-running prescaler phase never makes a correct design fail.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam logic [7:0] KEY_CLEAR = 8'h4E;
    localparam logic [7:0] KEY_STOP  = 8'hB1;
    localparam int         NUM_SEL   = 4;

    typedef enum logic {
        SLOT_CTRL = 1'b0,
        SLOT_KEY  = 1'b1
    } slot_e;

    typedef struct packed {
        logic       en;
        logic [1:0] sel;
        logic       rst_mode;
        logic       run;
    } ctrl_t;

    localparam ctrl_t CTRL_INIT = '{en: 1'b1, sel: 2'b00, rst_mode: 1'b1, run: 1'b1};

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic       addr_i,
    input  logic [7:0] wdata_i,
    output ctrl_t      ctrl_o,
    output logic       clr_o
);

    ctrl_t st_d, st_q;
    slot_e slot;

    assign slot = slot_e'(addr_i);

    always_comb begin
        st_d  = st_q;
        clr_o = 1'b0;
        if (wr_i) begin
            case (slot)
                SLOT_CTRL: begin
                    st_d.en       = wdata_i[3];
                    st_d.sel      = wdata_i[2:1];
                    // interrupt mode is one-way
                    st_d.rst_mode = st_q.rst_mode & wdata_i[0];
                    if (wdata_i[3] && !st_q.en) begin
                        st_d.run = 1'b1;
                        clr_o    = 1'b1;
                    end
                end
                SLOT_KEY: begin
                    if (wdata_i == KEY_CLEAR) begin
                        clr_o = 1'b1;
                    end else if (wdata_i == KEY_STOP && !st_q.en) begin
                        st_d.run = 1'b0;
                        clr_o    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTRL_INIT;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q;

    p_sticky_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.rst_mode |=> !st_q.rst_mode);

    p_stop_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> !$past(st_q.en));

    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> $past(clr_o));

endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
    import kwdt_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int TAP0  = 3,
    parameter int TAP1  = 4,
    parameter int TAP2  = 5,
    parameter int TAP3  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    output logic       tick_o
);

    localparam int TAPS [NUM_SEL] = '{TAP0, TAP1, TAP2, TAP3};

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [NUM_SEL-1:0] hit;

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
        assign hit[g] = &st_q.pre[TAPS[g]:0];
    end

    assign tick_o = hit[sel_i];

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (!tick_o || sel_i != $past(sel_i)));

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic clr_i,
    input  logic rst_mode_i,
    output logic irq_o,
    output logic rst_o
);

    localparam int RW = $clog2(RST_CYCLES + 1);
    localparam logic [RW-1:0] RST_LOAD = RW'(RST_CYCLES);

    typedef struct packed {
        logic [1:0]    cnt;
        logic          irq;
        logic [RW-1:0] hold;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     ovf;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        ovf      = 1'b0;
        if (st_q.hold != '0) st_d.hold = st_q.hold - 1'b1;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (run_i && tick_i) begin
            if (st_q.cnt == 2'd3) begin
                ovf      = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (ovf) begin
            if (rst_mode_i) st_d.hold = RST_LOAD;
            else            st_d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
    assign rst_o = (st_q.hold != '0);

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_irq_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !rst_mode_i);

    p_rst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_o) && RST_CYCLES > 1) |=> rst_o);

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> st_q.cnt == 2'd0);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int PRE_W      = 8,
    parameter int TAP0       = 3,
    parameter int TAP1       = 4,
    parameter int TAP2       = 5,
    parameter int TAP3       = 6,
    parameter int RST_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic       wdt_irq,
    output logic       wdt_rst
);

    ctrl_t ctrl;
    logic  clr;
    logic  tick;

    kwdt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .ctrl_o  (ctrl),
        .clr_o   (clr)
    );

    kwdt_prescaler #(
        .PRE_W (PRE_W),
        .TAP0  (TAP0),
        .TAP1  (TAP1),
        .TAP2  (TAP2),
        .TAP3  (TAP3)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (ctrl.sel),
        .tick_o (tick)
    );

    kwdt_core #(
        .RST_CYCLES (RST_CYCLES)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .run_i      (ctrl.run),
        .clr_i      (clr),
        .rst_mode_i (ctrl.rst_mode),
        .irq_o      (wdt_irq),
        .rst_o      (wdt_rst)
    );

endmodule

// File: tb/sim_kwdt_top.sv
module sim_kwdt_top;

    localparam int CLK_PERIOD = 10;
    localparam int RST_CYCLES = 8;
    localparam int WD_LIMIT   = 60000;
    localparam int NV         = 4;
    localparam logic [1:0] V_SEL [NV] = '{2'd0, 2'd1, 2'd2, 2'd3};
    localparam int         V_DET [NV] = '{64, 128, 256, 512};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic wdt_irq, wdt_rst;

    int cyc = 0, compared = 0, mismatched = 0;
    int irq_cnt = 0, irq_last = 0, irq_prev = 0;
    int rst_rises = 0, rst_last = 0, rst_prev = 0, rst_width = 0, rst_run = 0;
    int wr_cyc = 0;
    logic rst_seen = 1'b0;

    kwdt_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wdt_irq   (wdt_irq),
        .wdt_rst   (wdt_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (wdt_irq) begin
                irq_cnt  <= irq_cnt + 1;
                irq_prev <= irq_last;
                irq_last <= cyc;
            end
            if (wdt_rst && !rst_seen) begin
                rst_rises <= rst_rises + 1;
                rst_prev  <= rst_last;
                rst_last  <= cyc;
                rst_run   <= 1;
            end else if (wdt_rst) begin
                rst_run <= rst_run + 1;
            end else if (rst_seen) begin
                rst_width <= rst_run;
            end
            rst_seen <= wdt_rst;
        end
        if (cyc > WD_LIMIT) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog expired (all requirements) actual %0d cycles expected < %0d", cyc, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int lo, input int hi);
        compared++;
        if (act < lo || act > hi) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        wr_cyc = cyc;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_irq(input int target, input int limit);
        for (int i = 0; i < limit && irq_cnt < target; i++) step(1);
    endtask

    task automatic wait_rst(input int target, input int limit);
        for (int i = 0; i < limit && rst_rises < target; i++) step(1);
    endtask

    int base, rel, rbase;

    initial begin
        step(5);
        #2 rst_n = 1'b1;
        base = cyc;
        step(1);
        // R1: outputs low after reset
        check("R1 irq after reset", int'(wdt_irq), 0, 0);
        check("R1 rst after reset", int'(wdt_rst), 0, 0);

        // R1/R8: default enabled, select 0, reset-output mode
        wait_rst(1, 200);
        check("R1 first overflow time", rst_last - base, 60, 70);
        step(RST_CYCLES + 3);
        check("R8 reset width", rst_width, RST_CYCLES, RST_CYCLES);
        check("R8 no irq in reset mode", irq_cnt, 0, 0);
        wait_rst(2, 200);
        check("R2 select 0 period", rst_last - rst_prev, 64, 64);

        // R3: clears faster than 3/4 keep it quiet
        rbase = rst_rises;
        for (int k = 0; k < 12; k++) begin
            bus_write(1'b1, 8'h4E);
            step(38);
        end
        check("R3 periodic clears suppress", rst_rises - rbase, 0, 0);
        bus_write(1'b1, 8'h4E);
        wait_rst(rbase + 1, 200);
        check("R3 overflow after clear", rst_last - wr_cyc, 47, 67);

        // R4: invalid code ignored
        rbase = rst_rises;
        for (int k = 0; k < 15; k++) begin
            bus_write(1'b1, 8'h4F);
            step(18);
        end
        check("R4 invalid code ignored", rst_rises - rbase, 4, 6);

        // R5: stop key ignored with enable at 1
        rbase = rst_rises;
        for (int k = 0; k < 15; k++) begin
            bus_write(1'b1, 8'hB1);
            step(18);
        end
        check("R5 stop key needs enable 0", rst_rises - rbase, 4, 6);

        // table: interrupt mode, each detection select
        for (int v = 0; v < NV; v++) begin
            bus_write(1'b0, {4'b0000, 1'b1, V_SEL[v], 1'b0});
            bus_write(1'b1, 8'h4E);
            rel = wr_cyc;
            step(RST_CYCLES + 2);
            base  = irq_cnt;
            rbase = rst_rises;
            wait_irq(base + 1, 2 * V_DET[v]);
            check("R3 first overflow after clear", irq_last - rel,
                  (3 * V_DET[v]) / 4 - 1, V_DET[v] + 3);
            wait_irq(base + 2, 2 * V_DET[v]);
            check("R2 detection period", irq_last - irq_prev, V_DET[v], V_DET[v]);
            check("R8 no reset in irq mode", rst_rises - rbase, 0, 0);
        end

        // R9: cannot return to reset mode
        bus_write(1'b0, 8'b0000_1001);
        bus_write(1'b1, 8'h4E);
        base  = irq_cnt;
        rbase = rst_rises;
        wait_irq(base + 1, 200);
        check("R9 irq still raised", irq_cnt - base, 1, 1);
        check("R9 reset stays low", rst_rises - rbase, 0, 0);

        // R6: enable 0 alone keeps counting
        bus_write(1'b0, 8'b0000_0000);
        base = irq_cnt;
        wait_irq(base + 1, 200);
        check("R6 counting continues", irq_cnt - base, 1, 1);

        // R5: stop key with enable 0 stops
        bus_write(1'b1, 8'hB1);
        step(3);
        base = irq_cnt;
        step(640);
        check("R5 stopped", irq_cnt - base, 0, 0);

        // R7: re-enable restarts from cleared counter
        bus_write(1'b0, 8'b0000_1000);
        rel = wr_cyc;
        wait_irq(base + 1, 200);
        check("R7 restart timing", irq_last - rel, 47, 67);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule